// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Software uses two byte addresses on a simple register bus. One is a control and status register that holds the frame mode, the address-filter enable, the receive enable, the outgoing ninth bit, the captured ninth bit and the two completion flags. The other is a shared data address: a write there loads the transmitter, and a read returns a separate receive holding register.

Three frame formats are available. One is an 8-bit frame timed by an external 16x baud tick. Two are 9-bit frames, one timed by the same baud tick and one derived from a fixed-rate tick divided by 64, or by 32 when the rate-doubling input is high. The receiver oversamples the line 16 times per bit. It confirms a start bit at mid-bit and takes a majority of three samples around each bit centre. An address-filter enable lets a receiver ignore frames whose ninth bit is 0, or, in 8-bit mode, frames that end in a bad stop bit. Those are the frames that carry data addressed to other nodes in a multi-drop network.

Top module: `serial_port_top`

## Requirements
- R1: After reset the control register reads 0x00, the transmit line is high and both flags are low.
- R2: The control register is at address 0x98 with bit 7..6 = mode, bit 5 = address filter, bit 4 = receive enable, bit 3 = transmit ninth bit, bit 2 = received ninth bit, bit 1 = transmit flag, bit 0 = receive flag. The data buffer is at 0x99. A read strobe returns the addressed value on the read bus at the next clock edge, and any other address reads 0x00.
- R3: Mode 01 is an 8-bit frame with 16 baud ticks per bit. Mode 11 is a 9-bit frame with 16 baud ticks per bit. Mode 10 is a 9-bit frame lasting 64 fixed ticks per bit, or 32 when rate doubling is high. In mode 00 buffer writes send nothing and nothing is received.
- R4: A transmitted frame is a low start bit, the data bits LSB first, then in 9-bit modes control bit 3, then a high stop bit. The line idles high.
- R5: The transmit flag rises at the start of the transmitted stop bit.
- R6: A buffer write while a frame is being sent is ignored.
- R7: A low pulse on the receive line that is no longer low at mid-bit of the start bit is rejected and starts no frame.
- R8: The receive flag rises midway through the received stop bit, and the received byte is read back at 0x99 independently of what was last written there.
- R9: If a second frame completes before the first is read, the holding register holds the second byte.
- R10: On an accepted frame, control bit 2 takes the received ninth bit in 9-bit modes and the received stop bit in 8-bit mode.
- R11: With the address filter set, a frame is dropped without raising the receive flag or changing the holding register or bit 2 when its ninth bit is 0 (9-bit modes) or its stop bit is 0 (8-bit mode). With the filter clear, every completed frame is accepted.
- R12: The flags are set only by the port. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R13: With receive enable clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| baud_tick16 | input | 1 | 16x baud tick for the variable-rate modes |
| fix_tick | input | 1 | Fixed-rate tick for mode 10 |
| rate_dbl | input | 1 | Halves the fixed-mode bit period |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| bus_rdata | output | 8 | Registered read data |
| ti_flag | output | 1 | Transmit flag (control bit 1) |
| ri_flag | output | 1 | Receive flag (control bit 0) |

## Verification
Transmit and receive are each exercised in all three active modes, with both rate settings in the fixed mode, using byte values whose bit patterns make LSB-first order and ninth-bit placement visible. Receive frames come with good and bad stop bits and with the ninth bit set and clear, each under filter on and filter off, so that the four accept/drop outcomes and the different meaning of the captured ninth bit in each mode can be told apart. Back-to-back frames without a read show overwrite. A short false start, a frame with receive disabled, a write to a busy transmitter and traffic in mode 00 each have to leave the observable state untouched.

// File: rtl/serial_port_pkg.sv
// Shared types and constants for the serial port.
// Assumes a 16x oversampling rate on both directions.
package serial_port_pkg;
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_8V  = 2'b01,
        MODE_9F  = 2'b10,
        MODE_9V  = 2'b11
    } port_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    localparam int OVS     = 16;
    localparam int TCW     = $clog2(OVS);
    localparam int MID     = OVS / 2;
endpackage

// File: rtl/serial_tickgen.sv
// Selects the 16x oversampling tick. In fixed mode the fixed-rate tick
// is divided by FIX_DIV (or FIX_DIV/2 when doubling); otherwise the
// external baud tick passes straight through. Assumes FIX_DIV >= 4.
module serial_tickgen #(
    parameter int FIX_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fixed_sel,
    input  logic rate_dbl,
    input  logic fix_tick,
    input  logic baud_tick16,
    output logic os_tick
);
    localparam int CW = $clog2(FIX_DIV) + 1;

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_lim;
    logic          fix_os;

    assign div_lim = rate_dbl ? CW'(FIX_DIV / 2 - 1) : CW'(FIX_DIV - 1);
    assign fix_os  = fixed_sel && fix_tick && (div_cnt >= div_lim);
    assign os_tick = fixed_sel ? fix_os : baud_tick16;

    // Purpose: count fixed ticks up to the selected divide limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!fixed_sel) begin
            div_cnt <= '0;
        end else if (fix_tick) begin
            div_cnt <= (div_cnt >= div_lim) ? '0 : div_cnt + CW'(1);
        end
    end

    // R3: divided fixed tick never fires on two cycles in a row
    assert_fixed_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_sel && os_tick) |=> !(fixed_sel && os_tick));
endmodule

// File: rtl/serial_tx.sv
// Transmit shifter: start bit, DW data bits LSB first, optional ninth
// bit, stop bit, each OVS ticks long. Loads only when idle.
// Assumes os_tick is a single-cycle pulse.
module serial_tx
    import serial_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          load,
    input  logic          nine,
    input  logic          bit9,
    input  logic [DW-1:0] din,
    output logic          txd,
    output logic          stop_start
);
    localparam int FW  = DW + 3;
    localparam int BCW = $clog2(FW + 1);

    logic [FW-1:0]  sh;
    logic [BCW-1:0] bidx;
    logic [BCW-1:0] last_idx;
    logic [TCW-1:0] tcnt;
    logic           nine_q;
    logic           busy;
    logic           bit_end;

    assign last_idx   = nine_q ? BCW'(DW + 2) : BCW'(DW + 1);
    assign bit_end    = busy && os_tick && (tcnt == TCW'(OVS - 1));
    assign stop_start = bit_end && (bidx == last_idx - BCW'(1));
    assign txd        = busy ? sh[0] : 1'b1;

    // Purpose: load a frame when idle, then shift one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sh     <= '1;
            bidx   <= '0;
            tcnt   <= '0;
            nine_q <= 1'b0;
        end else if (load && !busy) begin
            busy   <= 1'b1;
            sh     <= {1'b1, (nine ? bit9 : 1'b1), din, 1'b0};
            bidx   <= '0;
            tcnt   <= '0;
            nine_q <= nine;
        end else if (busy && os_tick) begin
            tcnt <= tcnt + TCW'(1);
            if (bit_end) begin
                sh <= {1'b1, sh[FW-1:1]};
                if (bidx == last_idx) begin
                    busy <= 1'b0;
                end else begin
                    bidx <= bidx + BCW'(1);
                end
            end
        end
    end

    // R4: the last bit before returning to idle was a high stop bit
    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));
endmodule

// File: rtl/serial_rx.sv
// Receive sampler: synchronises the line, waits for a low level, checks
// the start bit at mid-bit and votes 2-of-3 samples around each bit
// centre. Emits a one-cycle done pulse midway through the stop bit.
// Assumes os_tick runs at OVS times the bit rate.
module serial_rx
    import serial_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          enable,
    input  logic          nine,
    input  logic          rxd_raw,
    output logic          done,
    output logic [DW-1:0] dout,
    output logic          bit9,
    output logic          stop_ok
);
    localparam int BIW = $clog2(DW + 1);

    rx_state_e      state;
    logic           rx_m, rx_s;
    logic [TCW-1:0] tcnt;
    logic [BIW-1:0] bidx;
    logic [BIW-1:0] nd_last;
    logic [DW:0]    dbuf;
    logic [1:0]     vote;
    logic           vote_now;
    logic           at_mid;
    logic           at_end;

    assign nd_last  = nine ? BIW'(DW) : BIW'(DW - 1);
    assign vote_now = (vote[1] & vote[0]) | (vote[1] & rx_s) | (vote[0] & rx_s);
    assign at_mid   = (tcnt == TCW'(MID + 1));
    assign at_end   = (tcnt == TCW'(OVS - 1));
    assign dout     = dbuf[DW-1:0];
    assign bit9     = dbuf[DW];

    // Purpose: two-stage synchroniser on the incoming line, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd_raw;
            rx_s <= rx_m;
        end
    end

    // Purpose: keep the two samples taken just before the bit centre vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote <= 2'b11;
        end else if (os_tick && (tcnt == TCW'(MID - 1) || tcnt == TCW'(MID))) begin
            vote <= {vote[0], rx_s};
        end
    end

    // Purpose: frame state machine driven by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            dbuf    <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
                tcnt  <= '0;
            end else if (os_tick) begin
                case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        if (!rx_s) begin
                            state <= RX_START;
                        end
                    end
                    RX_START: begin
                        tcnt <= tcnt + TCW'(1);
                        if (at_mid && vote_now) begin
                            state <= RX_IDLE;
                        end else if (at_end) begin
                            state <= RX_DATA;
                            bidx  <= '0;
                        end
                    end
                    RX_DATA: begin
                        tcnt <= tcnt + TCW'(1);
                        if (at_mid) begin
                            dbuf[bidx] <= vote_now;
                        end
                        if (at_end) begin
                            if (bidx == nd_last) begin
                                state <= RX_STOP;
                            end else begin
                                bidx <= bidx + BIW'(1);
                            end
                        end
                    end
                    default: begin
                        tcnt <= tcnt + TCW'(1);
                        if (at_mid) begin
                            state   <= RX_IDLE;
                            stop_ok <= vote_now;
                            done    <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R7: a high line never starts a frame
    assert_no_start_from_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == RX_IDLE && os_tick && rx_s) |=> (state == RX_IDLE));
endmodule

// File: rtl/serial_port_top.sv
// Register-mapped full-duplex serial port. Holds the control/status
// register and the receive holding register, decodes the two bus
// addresses and applies the multiprocessor address filter.
// Assumes single-cycle write and read strobes.
module serial_port_top
    import serial_port_pkg::*;
#(
    parameter int          AW           = 8,
    parameter int          DW           = 8,
    parameter logic [AW-1:0] CTRL_ADDR  = 8'h98,
    parameter logic [AW-1:0] DATA_ADDR  = 8'h99,
    parameter int          FIX_BIT_CLKS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          baud_tick16,
    input  logic          fix_tick,
    input  logic          rate_dbl,
    input  logic          rxd,
    output logic          txd,
    output logic [DW-1:0] bus_rdata,
    output logic          ti_flag,
    output logic          ri_flag
);
    localparam int FIX_DIV = FIX_BIT_CLKS / OVS;

    port_mode_e    mode_q;
    logic          filt_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
    logic [DW-1:0] rx_hold;
    logic          wr_ctrl, wr_data;
    logic          os_tick, nine, port_on;
    logic          tx_stop_start;
    logic          rx_done, rx_bit9, rx_stop_ok, rx_accept;
    logic [DW-1:0] rx_dout;
    logic [7:0]    ctrl_view;

    assign wr_ctrl   = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_data   = bus_wr && (bus_addr == DATA_ADDR);
    assign nine      = mode_q[1];
    assign port_on   = (mode_q != MODE_OFF);
    assign rx_accept = rx_done && (!filt_q || (nine ? rx_bit9 : rx_stop_ok));
    assign ctrl_view = {mode_q, filt_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
    assign ti_flag   = ti_q;
    assign ri_flag   = ri_q;

    serial_tickgen #(.FIX_DIV(FIX_DIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_sel  (mode_q == MODE_9F),
        .rate_dbl   (rate_dbl),
        .fix_tick   (fix_tick),
        .baud_tick16(baud_tick16),
        .os_tick    (os_tick)
    );

    serial_tx #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .load      (wr_data && port_on),
        .nine      (nine),
        .bit9      (tb8_q),
        .din       (bus_wdata),
        .txd       (txd),
        .stop_start(tx_stop_start)
    );

    serial_rx #(.DW(DW)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_tick(os_tick),
        .enable (ren_q && port_on),
        .nine   (nine),
        .rxd_raw(rxd),
        .done   (rx_done),
        .dout   (rx_dout),
        .bit9   (rx_bit9),
        .stop_ok(rx_stop_ok)
    );

    // Purpose: software-writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            filt_q <= 1'b0;
            ren_q  <= 1'b0;
            tb8_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= port_mode_e'(bus_wdata[7:6]);
            filt_q <= bus_wdata[5];
            ren_q  <= bus_wdata[4];
            tb8_q  <= bus_wdata[3];
        end
    end

    // Purpose: flags set by hardware, cleared only by writing a 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ti_q <= 1'b0;
            ri_q <= 1'b0;
        end else begin
            ti_q <= tx_stop_start | (ti_q & ~(wr_ctrl & ~bus_wdata[1]));
            ri_q <= rx_accept     | (ri_q & ~(wr_ctrl & ~bus_wdata[0]));
        end
    end

    // Purpose: capture accepted frames into the holding register and bit 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rb8_q   <= 1'b0;
        end else if (rx_accept) begin
            rx_hold <= rx_dout;
            rb8_q   <= nine ? rx_bit9 : rx_stop_ok;
        end
    end

    // Purpose: registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == CTRL_ADDR) begin
                bus_rdata <= DW'(ctrl_view);
            end else if (bus_addr == DATA_ADDR) begin
                bus_rdata <= rx_hold;
            end else begin
                bus_rdata <= '0;
            end
        end
    end

    // R5: the transmit flag rises while the line carries the stop bit
    assert_ti_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti_q) |-> txd);

    // R13: no receive flag unless reception was enabled
    assert_ri_needs_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ri_q) |-> $past(ren_q));

    // R11: with the filter on in a 9-bit mode, only ninth-bit-1 frames flag
    assert_filter_ninth_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ri_q) && $past(filt_q) && $past(mode_q[1])) |-> rb8_q);

    // R12: a control write cannot set a cleared receive flag
    assert_no_sw_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ri_q && !rx_done) |=> !ri_q);
endmodule

// File: tb/serial_port_top_tb.sv
module serial_port_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       baud_tick16;
    logic       fix_tick = 1'b1;
    logic       rate_dbl = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] bus_rdata;
    logic       ti_flag, ri_flag;
    logic [1:0] bcnt = 2'd0;

    int checks = 0;
    int fails = 0;
    int bit_clks = 64;
    bit nine_m = 1'b0;
    logic [7:0] hold_m = 8'h00;
    logic       rb8_m = 1'b0;

    typedef struct { logic ri; logic rb8; logic [7:0] d; string req; } rx_exp_t;
    logic [8:0] exp_tx[$];
    rx_exp_t    exp_rx[$];

    always #4 clk = ~clk;

    always @(posedge clk) bcnt <= bcnt + 2'd1;
    assign baud_tick16 = (bcnt == 2'd3);

    serial_port_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .baud_tick16(baud_tick16),
        .fix_tick(fix_tick), .rate_dbl(rate_dbl), .rxd(rxd), .txd(txd),
        .bus_rdata(bus_rdata), .ti_flag(ti_flag), .ri_flag(ri_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * bit_clks) @(negedge clk);
    endtask

    // Driver: queue the expected frame, then load the transmitter.
    task automatic send_tx(input logic [7:0] d, input logic b9);
        exp_tx.push_back({(nine_m ? b9 : 1'b1), d});
        wr(8'h99, d);
    endtask

    // Driver: put one frame on the receive line.
    task automatic send_rx(input logic [7:0] d, input logic b9, input logic stopb, input bit ri_chk);
        @(negedge clk);
        rxd = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            wait_bits(1);
        end
        if (nine_m) begin
            rxd = b9;
            wait_bits(1);
        end
        rxd = stopb;
        repeat (bit_clks / 4) @(negedge clk);
        if (ri_chk) chk(ri_flag == 1'b0, "R8 flag low early in stop", ri_flag, 0);
        repeat (bit_clks - bit_clks / 4) @(negedge clk);
        rxd = 1'b1;
        wait_bits(1);
    endtask

    task automatic expect_rx(input logic ri, input logic rb8, input logic [7:0] d, input string req);
        rx_exp_t e;
        e.ri = ri; e.rb8 = rb8; e.d = d; e.req = req;
        exp_rx.push_back(e);
        if (ri) begin hold_m = d; rb8_m = rb8; end
    endtask

    // Receive monitor: pop the expectation and compare the port state.
    task automatic check_rx(input logic [7:0] ctrl_w);
        rx_exp_t e;
        logic [7:0] c, v;
        e = exp_rx.pop_front();
        rd(8'h98, c);
        rd(8'h99, v);
        chk(c[0] == e.ri, {e.req, " receive flag"}, c[0], e.ri);
        chk(c[2] == e.rb8, {e.req, " received ninth bit"}, c[2], e.rb8);
        chk(v == e.d, {e.req, " holding register"}, v, e.d);
        wr(8'h98, ctrl_w);
    endtask

    // Transmit monitor: decode every frame on txd and compare with the queue.
    initial begin
        forever begin
            logic [8:0] got;
            logic [8:0] e;
            int nd;
            logic sv;
            do @(negedge clk); while (txd !== 1'b0);
            nd = nine_m ? 9 : 8;
            got = 9'h1FF;
            repeat (bit_clks / 2) @(negedge clk);
            sv = txd;
            for (int i = 0; i < nd; i++) begin
                repeat (bit_clks) @(negedge clk);
                got[i] = txd;
            end
            chk(ti_flag == 1'b0, "R5 transmit flag low in last data bit", ti_flag, 0);
            repeat (bit_clks) @(negedge clk);
            chk(ti_flag == 1'b1, "R5 transmit flag high in stop bit", ti_flag, 1);
            chk(txd == 1'b1 && sv == 1'b0, "R4 start low and stop high", {sv, txd}, 1);
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R6/R3 unexpected frame", got, 0);
            end else begin
                e = exp_tx.pop_front();
                chk(got == e, "R4 frame bits", got, e);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h98, v);
        chk(v == 8'h00, "R1 control after reset", v, 8'h00);
        chk(txd == 1'b1 && ti_flag == 1'b0 && ri_flag == 1'b0, "R1 line and flags", {txd, ti_flag, ri_flag}, 3'b100);
        rd(8'h42, v);
        chk(v == 8'h00, "R2 unmapped address", v, 0);

        // Mode 01, receive on
        wr(8'h98, 8'h50);
        rd(8'h98, v);
        chk(v == 8'h50, "R2 control readback", v, 8'h50);

        // R4 R5 R6: transmit, with a write while busy
        send_tx(8'hA5, 1'b0);
        wait_bits(3);
        wr(8'h99, 8'h3C);
        wait_bits(9);
        rd(8'h98, v);
        chk(v == 8'h52, "R5 transmit flag in control", v, 8'h52);
        wr(8'h98, 8'h50);
        // R12: writing 1 to a clear flag leaves it clear
        wr(8'h98, 8'h53);
        rd(8'h98, v);
        chk(v == 8'h50, "R12 flags not set by software", v, 8'h50);

        // R8 R10: plain 8-bit receive
        send_rx(8'h3C, 1'b0, 1'b1, 1);
        expect_rx(1, 1, 8'h3C, "R8 8-bit receive");
        check_rx(8'h50);

        // R9: overwrite
        send_rx(8'h11, 1'b0, 1'b1, 1);
        send_rx(8'h22, 1'b0, 1'b1, 0);
        expect_rx(1, 1, 8'h22, "R9 overwrite");
        check_rx(8'h50);

        // R11: filter on, bad stop dropped, good stop taken
        wr(8'h98, 8'h70);
        send_rx(8'h55, 1'b0, 1'b0, 1);
        expect_rx(0, rb8_m, hold_m, "R11 bad stop dropped");
        check_rx(8'h70);
        send_rx(8'h66, 1'b0, 1'b1, 1);
        expect_rx(1, 1, 8'h66, "R11 good stop accepted");
        check_rx(8'h50);

        // R10 R11: filter off, bad stop accepted, stop bit captured as 0
        send_rx(8'h77, 1'b0, 1'b0, 1);
        expect_rx(1, 0, 8'h77, "R10 stop bit captured");
        check_rx(8'h50);

        // R7: short false start
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wait_bits(2);
        expect_rx(0, rb8_m, hold_m, "R7 false start rejected");
        check_rx(8'h50);
        send_rx(8'h81, 1'b0, 1'b1, 1);
        expect_rx(1, 1, 8'h81, "R7 receive after false start");
        check_rx(8'h40);

        // R13: receive disabled
        send_rx(8'h99, 1'b0, 1'b1, 1);
        expect_rx(0, rb8_m, hold_m, "R13 disabled receiver");
        check_rx(8'hD8);

        // R3 R4: mode 11, 9-bit variable
        nine_m = 1'b1;
        send_tx(8'h5A, 1'b1);
        wait_bits(12);
        wr(8'h98, 8'hD0);
        send_tx(8'h96, 1'b0);
        wait_bits(12);
        wr(8'h98, 8'hD0);
        send_rx(8'hC3, 1'b0, 1'b1, 1);
        expect_rx(1, 0, 8'hC3, "R10 ninth bit 0 captured");
        check_rx(8'hF0);
        // R11: 9-bit filter
        send_rx(8'h24, 1'b0, 1'b1, 1);
        expect_rx(0, rb8_m, hold_m, "R11 ninth bit 0 dropped");
        check_rx(8'hF0);
        send_rx(8'h42, 1'b1, 1'b1, 1);
        expect_rx(1, 1, 8'h42, "R11 ninth bit 1 accepted");
        check_rx(8'h98);

        // R3: mode 10 fixed rate, divide by 64 then by 32
        send_tx(8'h90, 1'b1);
        wait_bits(12);
        wr(8'h98, 8'h90);
        send_rx(8'h0F, 1'b1, 1'b1, 1);
        expect_rx(1, 1, 8'h0F, "R3 fixed rate 64");
        check_rx(8'h90);
        rate_dbl = 1'b1;
        bit_clks = 32;
        send_tx(8'h3A, 1'b0);
        wait_bits(12);
        wr(8'h98, 8'h90);
        send_rx(8'hE7, 1'b0, 1'b1, 1);
        expect_rx(1, 0, 8'hE7, "R3 fixed rate 32");
        check_rx(8'h10);

        // R3: mode 00 sends and receives nothing
        rate_dbl = 1'b0;
        bit_clks = 64;
        nine_m = 1'b0;
        wr(8'h99, 8'hFF);
        wait_bits(12);
        chk(txd == 1'b1, "R3 mode 00 line idle", txd, 1);
        send_rx(8'h5C, 1'b0, 1'b1, 1);
        expect_rx(0, rb8_m, hold_m, "R3 mode 00 no receive");
        check_rx(8'h10);

        chk(exp_tx.size() == 0, "R4 all frames sent", exp_tx.size(), 0);
        summary();
        $finish;
    end
endmodule